// File: doc/BRIEF.md
# Four-Source Latched Interrupt Controller

This block collects four interrupt sources for an 8-bit CPU and drives one active-low interrupt request pin. The sources are a variable-rate source, a once-per-second tick, and two external interrupt pins: one fed by the video controller's frame interrupt and one spare pin for a network port. Every source has an enable and a pending latch. A latch holds its event until software clears it, so an event that arrives while the CPU has interrupts masked is still taken later.

The CPU reaches the block through one I/O register. A write loads all four enables and fires one-shot clears for any latches selected. A read returns, for each source, its live input level next to its latch state. The variable source takes one of four strobes, chosen by a 2-bit select input. The tick generators and tone oscillators sit outside the block and arrive as single-cycle strobes.

The I/O port uses plain read and write strobes. It carries no stream, so there is no valid/ready handshake and no back-pressure: a write takes effect on the clock edge where `io_wr` is high, and read data is valid in the same cycle as `io_rd`.

Top module: `quad_irq_ctrl`

## Requirements
- R1: After reset all enables and latches are zero and `cpu_int_n` is 1. With both external pins high, a read of the register returns 0x50.
- R2: A write to address `REG_ADDR` (default 0xB4) loads the enables from data bits 0 (variable source), 2 (1 Hz), 4 (external pin 1) and 6 (external pin 2). The new enables apply from the next cycle.
- R3: `var_sel` picks the variable source's strobe: 00 = `tick_1khz`, 01 = `tick_50hz`, 10 = `tone0_tick`, 11 = `tone1_tick`. The three strobes that are not selected have no effect.
- R4: When the 1 Hz source is enabled, a `tick_1hz` pulse sets its latch at that clock edge.
- R5: An enabled external pin sets its latch on a falling edge, seen through a 2-flop synchroniser. If the pin goes low before edge E0, the latch is set at edge E2. A pin held low or rising does not set the latch.
- R6: A source that is disabled never sets its latch.
- R7: Writing 1 to data bit 1, 3, 5 or 7 clears the latch of the variable source, the 1 Hz source, pin 1 or pin 2 respectively, once. Writing 0 to such a bit leaves that latch unchanged.
- R8: If a clear and a set event reach the same latch in the same cycle, the set wins and the latch stays 1.
- R9: A read of `REG_ADDR` returns, for source k (0 = variable, 1 = 1 Hz, 2 = pin 1, 3 = pin 2), its live level on bit 2k and its latch on bit 2k+1. The live level is the selected strobe, `tick_1hz`, or the synchronised pin.
- R10: `cpu_int_n` is 0 exactly while at least one source is both enabled and latched. Disabling a source releases the request without clearing its latch.
- R11: Changing `var_sel` does not clear a pending variable-source latch.
- R12: Writes to any other address have no effect. `io_rdata` is 0 unless `io_rd` is high and the address matches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_addr | input | 8 | I/O address |
| io_wdata | input | 8 | Write data |
| io_wr | input | 1 | Write strobe |
| io_rd | input | 1 | Read strobe |
| io_rdata | output | 8 | Read data, 0 when not selected |
| tick_1khz | input | 1 | 1 kHz strobe |
| tick_50hz | input | 1 | 50 Hz strobe |
| tone0_tick | input | 1 | Tone channel 0 strobe |
| tone1_tick | input | 1 | Tone channel 1 strobe |
| tick_1hz | input | 1 | 1 Hz strobe |
| var_sel | input | 2 | Variable-source select |
| ext_int1_n | input | 1 | External pin 1 (video frame), falling-edge active |
| ext_int2_n | input | 1 | External pin 2 (network), falling-edge active |
| cpu_int_n | output | 1 | Active-low interrupt request |

## Verification
The bench goes after these corner cases:
- A clear that lands in the same cycle as a set event. A design that gave the clear priority would lose that event.
- An external pin held low after its latch is cleared. A level-sensitive design would set the latch again at once.
- The exact synchroniser latency of the external pins, so that an edge detector with a missing or extra stage shows up at the expected read cycle.
- Disabling a pending source. A design that cleared the latch on disable would lose the event; one that ignored the enable would keep the request asserted.
- Switching `var_sel` while the variable latch is pending, and strobes that are not selected. A design with a wrong select decode would latch the wrong tick.

// File: rtl/quad_irq_pkg.sv
package quad_irq_pkg;
  localparam int NSRC = 4;
  localparam int NPIN = 2;

  localparam int SRC_VAR  = 0;
  localparam int SRC_SEC  = 1;
  localparam int SRC_PIN1 = 2;
  localparam int SRC_PIN2 = 3;

  typedef enum logic [1:0] {
    VSEL_1K    = 2'b00,
    VSEL_50    = 2'b01,
    VSEL_TONE0 = 2'b10,
    VSEL_TONE1 = 2'b11
  } vsel_e;

  // Interleave level and latch: bit 2k = level, bit 2k+1 = latch
  function automatic logic [2*NSRC-1:0] pack_status(
    input logic [NSRC-1:0] lvl,
    input logic [NSRC-1:0] lat
  );
    logic [2*NSRC-1:0] r;
    for (int k = 0; k < NSRC; k++) begin
      r[2*k]   = lvl[k];
      r[2*k+1] = lat[k];
    end
    return r;
  endfunction
endpackage

// File: rtl/qirq_var_mux.sv
module qirq_var_mux
  import quad_irq_pkg::*;
(
  input  logic       tick_1khz,
  input  logic       tick_50hz,
  input  logic       tone0_tick,
  input  logic       tone1_tick,
  input  logic [1:0] var_sel,
  output logic       var_evt
);
  always_comb begin
    unique case (vsel_e'(var_sel))
      VSEL_1K:    var_evt = tick_1khz;
      VSEL_50:    var_evt = tick_50hz;
      VSEL_TONE0: var_evt = tone0_tick;
      VSEL_TONE1: var_evt = tone1_tick;
      default:    var_evt = 1'b0;
    endcase
  end
endmodule

// File: rtl/qirq_pin_edge.sv
module qirq_pin_edge #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_n,
  output logic level,
  output logic fall
);
  localparam int MSB = SYNC_STAGES - 1;

  logic [MSB:0] sync_q;
  logic         prev_q;

  generate
    if (SYNC_STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) sync_q <= '1;
        else        sync_q <= pin_n;
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) sync_q <= '1;
        else        sync_q <= {sync_q[MSB-1:0], pin_n};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) prev_q <= 1'b1;
    else        prev_q <= sync_q[MSB];

  assign level = sync_q[MSB];
  assign fall  = prev_q & ~sync_q[MSB];
endmodule

// File: rtl/qirq_src_latch.sv
module qirq_src_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic evt,
  input  logic clr,
  output logic pending
);
  // a set event outranks a clear in the same cycle
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)              pending <= 1'b0;
    else if (enable && evt)  pending <= 1'b1;
    else if (clr)            pending <= 1'b0;
endmodule

// File: rtl/quad_irq_ctrl.sv
module quad_irq_ctrl
  import quad_irq_pkg::*;
#(
  parameter logic [7:0] REG_ADDR    = 8'hB4,
  parameter int         SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] io_addr,
  input  logic [7:0] io_wdata,
  input  logic       io_wr,
  input  logic       io_rd,
  output logic [7:0] io_rdata,
  input  logic       tick_1khz,
  input  logic       tick_50hz,
  input  logic       tone0_tick,
  input  logic       tone1_tick,
  input  logic       tick_1hz,
  input  logic [1:0] var_sel,
  input  logic       ext_int1_n,
  input  logic       ext_int2_n,
  output logic       cpu_int_n
);
  logic            wr_hit, rd_hit;
  logic [NSRC-1:0] en_q, lat_q, evt, lvl, clr;
  logic [NPIN-1:0] pins_n, pin_lvl, pin_fall;
  logic            var_evt;

  assign wr_hit = io_wr && (io_addr == REG_ADDR);
  assign rd_hit = io_rd && (io_addr == REG_ADDR);

  qirq_var_mux u_vmux (
    .tick_1khz (tick_1khz),
    .tick_50hz (tick_50hz),
    .tone0_tick(tone0_tick),
    .tone1_tick(tone1_tick),
    .var_sel   (var_sel),
    .var_evt   (var_evt)
  );

  assign pins_n = {ext_int2_n, ext_int1_n};

  generate
    for (genvar p = 0; p < NPIN; p++) begin : g_pin
      qirq_pin_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
        .clk  (clk),
        .rst_n(rst_n),
        .pin_n(pins_n[p]),
        .level(pin_lvl[p]),
        .fall (pin_fall[p])
      );
    end
  endgenerate

  assign evt = {pin_fall[1], pin_fall[0], tick_1hz, var_evt};
  assign lvl = {pin_lvl[1],  pin_lvl[0],  tick_1hz, var_evt};

  generate
    for (genvar k = 0; k < NSRC; k++) begin : g_src
      assign clr[k] = wr_hit && io_wdata[2*k+1];

      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n)      en_q[k] <= 1'b0;
        else if (wr_hit) en_q[k] <= io_wdata[2*k];

      qirq_src_latch u_lat (
        .clk    (clk),
        .rst_n  (rst_n),
        .enable (en_q[k]),
        .evt    (evt[k]),
        .clr    (clr[k]),
        .pending(lat_q[k])
      );
    end
  endgenerate

  assign io_rdata  = rd_hit ? pack_status(lvl, lat_q) : 8'h00;
  assign cpu_int_n = ~|(en_q & lat_q);
endmodule

// File: rtl/quad_irq_chk.sv
module quad_irq_chk #(
  parameter logic [7:0] REG_ADDR = 8'hB4
) (
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] io_addr,
  input logic [7:0] io_wdata,
  input logic       io_wr,
  input logic       io_rd,
  input logic [7:0] io_rdata,
  input logic       tick_1hz,
  input logic       cpu_int_n,
  input logic [3:0] en_q,
  input logic [3:0] lat_q,
  input logic       var_evt
);
  logic wr_hit;
  assign wr_hit = io_wr && (io_addr == REG_ADDR);

  AST_ENABLE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hit |=> en_q == $past({io_wdata[6], io_wdata[4], io_wdata[2], io_wdata[0]})); // R2

  AST_NO_SET_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_q[1] && !lat_q[1]) |=> !lat_q[1]); // R6

  AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit && io_wdata[1] && !var_evt) |=> !lat_q[0]); // R7

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q[1] && tick_1hz) |=> lat_q[1]); // R8

  AST_DISABLE_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit && !io_wdata[0] && !io_wdata[2] && !io_wdata[4] && !io_wdata[6]) |=> cpu_int_n); // R10

  AST_PENDING_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (lat_q[0] && !(wr_hit && io_wdata[1])) |=> lat_q[0]); // R11

  AST_IDLE_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !io_rd |-> io_rdata == 8'h00); // R12
endmodule

bind quad_irq_ctrl quad_irq_chk #(.REG_ADDR(REG_ADDR)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .io_addr  (io_addr),
  .io_wdata (io_wdata),
  .io_wr    (io_wr),
  .io_rd    (io_rd),
  .io_rdata (io_rdata),
  .tick_1hz (tick_1hz),
  .cpu_int_n(cpu_int_n),
  .en_q     (en_q),
  .lat_q    (lat_q),
  .var_evt  (var_evt)
);

// File: tb/quad_irq_ctrl_bench.sv
module quad_irq_ctrl_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic [7:0] io_addr = 8'hB4, io_wdata = 8'h00, io_rdata;
  logic io_wr = 0, io_rd = 0;
  logic t1k = 0, t50 = 0, tn0 = 0, tn1 = 0, t1hz = 0;
  logic [1:0] sel = 2'b00;
  logic p1 = 1, p2 = 1;
  logic cpu_int_n;

  int n_tests = 0, n_fail = 0;
  bit auto_on = 0, done = 0;

  quad_irq_ctrl u_quad_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wdata(io_wdata),
    .io_wr(io_wr), .io_rd(io_rd), .io_rdata(io_rdata),
    .tick_1khz(t1k), .tick_50hz(t50), .tone0_tick(tn0), .tone1_tick(tn1),
    .tick_1hz(t1hz), .var_sel(sel), .ext_int1_n(p1), .ext_int2_n(p2),
    .cpu_int_n(cpu_int_n)
  );

  // reference model built from the requirements
  logic [3:0] m_en, m_lat;
  logic [1:0] m_s1, m_s2, m_sp;

  function automatic logic sel_strobe();
    case (sel)
      2'b00:   return t1k;
      2'b01:   return t50;
      2'b10:   return tn0;
      default: return tn1;
    endcase
  endfunction

  function automatic logic [7:0] exp_rd();
    logic [3:0] lv;
    lv = {m_s2[1], m_s2[0], t1hz, sel_strobe()};
    if (!(io_rd && io_addr == 8'hB4)) return 8'h00;
    return {m_lat[3], lv[3], m_lat[2], lv[2], m_lat[1], lv[1], m_lat[0], lv[0]};
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_en <= 0; m_lat <= 0; m_s1 <= 2'b11; m_s2 <= 2'b11; m_sp <= 2'b11;
    end else begin
      logic hit;
      logic [3:0] ev, cl;
      hit = io_wr && io_addr == 8'hB4;
      ev  = {m_sp[1] & ~m_s2[1], m_sp[0] & ~m_s2[0], t1hz, sel_strobe()};
      cl  = hit ? {io_wdata[7], io_wdata[5], io_wdata[3], io_wdata[1]} : 4'h0;
      m_lat <= (m_lat & ~cl) | (ev & m_en);
      if (hit) m_en <= {io_wdata[6], io_wdata[4], io_wdata[2], io_wdata[0]};
      m_s1 <= {p2, p1}; m_s2 <= m_s1; m_sp <= m_s2;
    end
  end

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic cyc();
    #1;
    if (auto_on) begin
      chk("R9 model read", io_rdata, exp_rd());
      chk("R10 model irq", {7'b0, cpu_int_n}, {7'b0, ~|(m_en & m_lat)});
    end
    @(negedge clk);
    io_wr = 0; io_rd = 0; t1k = 0; t50 = 0; tn0 = 0; tn1 = 0; t1hz = 0;
    io_addr = 8'hB4;
  endtask

  task automatic wr(input logic [7:0] d, input logic [7:0] a = 8'hB4);
    io_wr = 1; io_wdata = d; io_addr = a; cyc();
  endtask

  task automatic rd_chk(input string tag, input logic [7:0] exp, input logic [7:0] a = 8'hB4);
    io_rd = 1; io_addr = a; #1; chk(tag, io_rdata, exp); cyc();
  endtask

  task automatic irq_chk(input string tag, input logic exp);
    #1; chk(tag, {7'b0, cpu_int_n}, {7'b0, exp});
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    auto_on = 1;
    irq_chk("R1 irq idle", 1'b1);
    rd_chk("R1 reset read", 8'h50);

    // variable source, 1 kHz
    wr(8'h01);
    t1k = 1; cyc();
    irq_chk("R10 irq asserted", 1'b0);
    rd_chk("R9 layout var latch", 8'h52);
    wr(8'h03);
    irq_chk("R7 clear releases", 1'b1);
    rd_chk("R7 latch cleared", 8'h50);
    t50 = 1; tn0 = 1; tn1 = 1; cyc();
    rd_chk("R3 unselected ignored", 8'h50);
    sel = 2'b01; t50 = 1; cyc();
    rd_chk("R3 sel 01 takes 50Hz", 8'h52);
    sel = 2'b10; cyc();
    rd_chk("R11 select change keeps latch", 8'h52);
    wr(8'h03);
    sel = 2'b11; tn1 = 1; cyc();
    rd_chk("R3 sel 11 takes tone1", 8'h52);
    wr(8'h01);
    rd_chk("R7 zero clear bit keeps", 8'h52);
    io_wr = 1; io_wdata = 8'h03; tn1 = 1; cyc();
    rd_chk("R8 set beats clear", 8'h52);
    wr(8'h00);
    irq_chk("R10 disable releases", 1'b1);
    rd_chk("R10 latch survives disable", 8'h52);
    wr(8'h01);
    irq_chk("R10 re-enable asserts", 1'b0);
    wr(8'h02);

    // 1 Hz
    t1hz = 1; cyc();
    rd_chk("R6 disabled no set", 8'h50);
    wr(8'h04);
    t1hz = 1; cyc();
    rd_chk("R4 1Hz latch", 8'h58);
    irq_chk("R4 irq", 1'b0);
    wr(8'h08);
    irq_chk("R7 1Hz clear", 1'b1);

    // external pin 1
    wr(8'h10);
    p1 = 0; cyc(); cyc();
    rd_chk("R5 not yet latched", 8'h40);
    rd_chk("R5 latched after sync", 8'h60);
    irq_chk("R5 irq", 1'b0);
    wr(8'h30);
    cyc(); cyc(); cyc();
    rd_chk("R5 steady low no reset", 8'h40);
    p1 = 1; cyc(); cyc(); cyc(); cyc();
    rd_chk("R5 rise no set", 8'h50);

    // external pin 2
    wr(8'h40);
    p2 = 0; cyc(); cyc(); cyc();
    rd_chk("R5 pin2 latched", 8'h90);
    irq_chk("R10 pin2 irq", 1'b0);
    wr(8'h80);
    rd_chk("R7 pin2 cleared", 8'h10);
    p2 = 1; cyc(); cyc(); cyc();

    // address decode
    wr(8'h55, 8'hB5);
    t1k = 1; sel = 2'b00; cyc();
    rd_chk("R12 foreign write ignored", 8'h50);
    rd_chk("R12 foreign read zero", 8'h00, 8'hB5);
    io_rd = 0; #1; chk("R12 no strobe zero", io_rdata, 8'h00); cyc();
    wr(8'h00);

    // constrained random against the model
    void'($urandom(32'h0001_2345));
    for (int i = 0; i < 4000; i++) begin
      io_wr = ($urandom % 8) == 0;
      io_addr = (($urandom % 8) == 0) ? 8'hB5 : 8'hB4;
      io_wdata = 8'($urandom);
      io_rd = $urandom % 2;
      t1k = ($urandom % 5) == 0; t50 = ($urandom % 5) == 0;
      tn0 = ($urandom % 5) == 0; tn1 = ($urandom % 5) == 0;
      t1hz = ($urandom % 7) == 0;
      if (($urandom % 16) == 0) sel = 2'($urandom);
      if (($urandom % 10) == 0) p1 = ~p1;
      if (($urandom % 10) == 0) p2 = ~p2;
      cyc();
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule